// File: doc/BRIEF.md
# Compressed Instruction Fetch Aligner

This block sits between a fetch unit and an instruction decoder in a core where 16-bit compressed and 32-bit instructions are mixed. The fetch unit delivers aligned 32-bit words, and each word arrives with a valid strobe and the program counter of the instruction being fetched. Bit 1 of that PC says whether the instruction starts in the lower or the upper halfword of the word.

The aligner extracts the instruction from the word. A 32-bit instruction that starts in the upper halfword runs into the next fetch word. In that case the aligner keeps its first half in a pending state and completes it from the low halfword of the next accepted word. The result is held in a registered instruction word, together with:
- a ready flag,
- a compressed flag,
- a request for more fetch bytes,
- the sequential next PC.

The decoder takes the instruction by pulsing a consume input. A synchronous flush, raised for example on a redirect, drops all state.

Top module: `cfetch_align`

## Requirements
- R1: An instruction is compressed exactly when its bits [1:0] are not 2'b11. `comp_o` reports this for the held instruction whenever `insn_rdy_o` is high.
- R2: A word is accepted when `fetch_vld_i` is high and no pending half is held. If `fetch_pc_i[1]` is 0, the whole word is captured. For a compressed instruction, bits [31:16] of `insn_o` read zero. `insn_rdy_o` is high in the cycle after acceptance.
- R3: After acceptance, `more_o` takes these values:
  - 0 for a compressed instruction at an aligned PC;
  - 1 for a full-width instruction at an aligned PC;
  - 1 for any instruction started at the upper halfword;
  - 0 once a pending instruction completes.
- R4: A word accepted with `fetch_pc_i[1]` = 1 and no pending half places its bits [31:16] in `insn_o[15:0]`, and `insn_o[31:16]` is zero. If that halfword is compressed, the instruction is ready in the next cycle. Otherwise the block enters the pending state and `insn_rdy_o` stays low.
- R5: In the pending state, the next accepted word puts its bits [15:0] into `insn_o[31:16]`. The `fetch_pc_i` of that word is ignored. The instruction becomes ready and the pending state ends. While pending, `insn_o[31:16]` is zero.
- R6: While `insn_rdy_o` is high, `next_pc_o` equals the start address plus 2 for a compressed instruction and plus 4 otherwise, modulo 2^ADDR_W. The start address of a spanning instruction is the PC given with its first word.
- R7: Ready is a handshake.
  - While `insn_rdy_o` is high and `consume_i` is low, `insn_o` holds and fetch words are ignored.
  - `consume_i` alone clears `insn_rdy_o` in the next cycle.
  - `consume_i` together with a valid word accepts that word.
- R8: Reset or `flush_i` puts the block in this state at the next edge:
  - `insn_o` = 32'h0000_0013;
  - `insn_rdy_o` = 0;
  - `more_o` = 1;
  - no pending half.

  `flush_i` wins over a valid word in the same cycle, and it discards a pending half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Synchronous flush, same effect as reset |
| fetch_vld_i | input | 1 | Fetch word valid |
| fetch_word_i | input | ILEN | Aligned fetch word |
| fetch_pc_i | input | ADDR_W | PC of the instruction being fetched; bit 1 selects the halfword |
| consume_i | input | 1 | Decoder takes the held instruction |
| insn_o | output | ILEN | Assembled instruction |
| insn_rdy_o | output | 1 | Instruction valid and not yet consumed |
| comp_o | output | 1 | Held instruction is compressed |
| more_o | output | 1 | Fetch unit should supply more bytes |
| next_pc_o | output | ADDR_W | Sequential PC after the held instruction |

## Verification
The bench builds the aligner with ADDR_W = 16 so that the next-PC wrap from 16'hFFFE to 16'h0000 can be reached with a short directed case. The default instruction width stays at 32.

A behavioural model runs alongside the design through random streams with these properties:
- valid, consume and flush toggle at random;
- halfword offsets are random;
- compressed and full-width encodings are mixed.

These streams reach spanning instructions that are interrupted by flushes, and back-to-back accept-and-consume cycles.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
  // low two bits of an instruction decide its length
  localparam logic [1:0] FULL_TAG = 2'b11;

  function automatic logic is_short(input logic [1:0] lo);
    return lo != FULL_TAG;
  endfunction
endpackage

// File: rtl/cfa_assemble.sv
module cfa_assemble #(
  parameter int ILEN = 32
) (
  input  logic            mid_i,
  input  logic            upper_i,
  input  logic [ILEN-1:0] word_i,
  input  logic [ILEN-1:0] held_i,
  output logic [ILEN-1:0] insn_o,
  output logic            done_o,
  output logic            more_o,
  output logic            mid_o
);
  import cfa_pkg::*;
  localparam int HALF = ILEN / 2;

  logic [HALF-1:0] lo_h, hi_h;
  assign lo_h = word_i[HALF-1:0];
  assign hi_h = word_i[ILEN-1:HALF];

  always_comb begin
    insn_o = held_i;
    done_o = 1'b0;
    more_o = 1'b1;
    mid_o  = 1'b0;
    if (mid_i) begin
      insn_o = {lo_h, held_i[HALF-1:0]};
      done_o = 1'b1;
      more_o = 1'b0;
    end else if (!upper_i) begin
      done_o = 1'b1;
      if (is_short(lo_h[1:0])) begin
        insn_o = {{HALF{1'b0}}, lo_h};
        more_o = 1'b0;
      end else begin
        insn_o = word_i;
      end
    end else begin
      insn_o = {{HALF{1'b0}}, hi_h};
      done_o = is_short(hi_h[1:0]);
      mid_o  = !is_short(hi_h[1:0]);
    end
  end
endmodule

// File: rtl/cfa_pc_step.sv
module cfa_pc_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic              short_i,
  output logic [ADDR_W-1:0] next_o
);
  localparam logic [ADDR_W-1:0] STEP_S = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_F = ADDR_W'(4);

  assign next_o = base_i + (short_i ? STEP_S : STEP_F);
endmodule

// File: rtl/cfetch_align.sv
module cfetch_align #(
  parameter int          ILEN     = 32,
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] NOP_WORD = 32'h0000_0013
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic              fetch_vld_i,
  input  logic [ILEN-1:0]   fetch_word_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              consume_i,
  output logic [ILEN-1:0]   insn_o,
  output logic              insn_rdy_o,
  output logic              comp_o,
  output logic              more_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  import cfa_pkg::*;
  localparam int HALF = ILEN / 2;

  logic [ILEN-1:0]   insn_q;
  logic              rdy_q, more_q, mid_q;
  logic [ADDR_W-1:0] addr_q, npc_q;

  logic [ILEN-1:0]   a_insn;
  logic              a_done, a_more, a_mid;
  logic [ADDR_W-1:0] step_base, step_next;
  logic              take, clr;

  assign clr  = rst | flush_i;
  assign take = fetch_vld_i & (~rdy_q | consume_i);

  cfa_assemble #(.ILEN(ILEN)) asm_i (
    .mid_i   (mid_q),
    .upper_i (fetch_pc_i[1]),
    .word_i  (fetch_word_i),
    .held_i  (insn_q),
    .insn_o  (a_insn),
    .done_o  (a_done),
    .more_o  (a_more),
    .mid_o   (a_mid)
  );

  assign step_base = mid_q ? addr_q : fetch_pc_i;

  cfa_pc_step #(.ADDR_W(ADDR_W)) step_i (
    .base_i  (step_base),
    .short_i (is_short(a_insn[1:0])),
    .next_o  (step_next)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      insn_q <= ILEN'(NOP_WORD);
      rdy_q  <= 1'b0;
      more_q <= 1'b1;
      mid_q  <= 1'b0;
      addr_q <= '0;
      npc_q  <= '0;
    end else if (take) begin
      insn_q <= a_insn;
      rdy_q  <= a_done;
      more_q <= a_more;
      mid_q  <= a_mid;
      if (!mid_q) addr_q <= fetch_pc_i;
      if (a_done) npc_q <= step_next;
    end else if (consume_i) begin
      rdy_q <= 1'b0;
    end
  end

  assign insn_o     = insn_q;
  assign insn_rdy_o = rdy_q;
  assign comp_o     = is_short(insn_q[1:0]);
  assign more_o     = more_q;
  assign next_pc_o  = npc_q;

  AST_PEND_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    mid_q |-> insn_q[ILEN-1:HALF] == '0);  // R5
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rdy_q && !consume_i && !flush_i) |=> (rdy_q && $stable(insn_q)));  // R7
  AST_FLUSH_STATE: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (!rdy_q && more_q && !mid_q && insn_q == ILEN'(NOP_WORD)));  // R8
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    rdy_q |-> (npc_q - addr_q) == (comp_o ? ADDR_W'(2) : ADDR_W'(4)));  // R6
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdy_q && comp_o) |-> insn_q[ILEN-1:HALF] == '0);  // R2
  AST_NO_READY_PENDING: assert property (@(posedge clk) disable iff (rst)
    mid_q |-> (!rdy_q && more_q));  // R4
endmodule

// File: tb/cfetch_align_tb.sv
module cfetch_align_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, vld = 1'b0, cons = 1'b0;
  logic [31:0] word = '0;
  logic [AW-1:0] pc = '0;
  logic [31:0] insn;
  logic rdy, comp, more;
  logic [AW-1:0] npc;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfetch_align #(.ILEN(32), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .flush_i(flush), .fetch_vld_i(vld),
    .fetch_word_i(word), .fetch_pc_i(pc), .consume_i(cons),
    .insn_o(insn), .insn_rdy_o(rdy), .comp_o(comp), .more_o(more),
    .next_pc_o(npc)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model, updated on each edge, compared shortly after
  logic [31:0] m_insn = 32'h13;
  logic m_rdy = 1'b0, m_more = 1'b1, m_mid = 1'b0;
  logic [AW-1:0] m_addr = '0, m_npc = '0;

  always @(posedge clk) begin
    if (rst || flush) begin
      m_insn = 32'h13; m_rdy = 0; m_more = 1; m_mid = 0; m_addr = '0; m_npc = '0;
    end else if (vld && (!m_rdy || cons)) begin
      if (m_mid) begin
        m_insn = {word[15:0], m_insn[15:0]};
        m_rdy = 1; m_more = 0; m_mid = 0; m_npc = m_addr + 4;
      end else if (!pc[1]) begin
        m_addr = pc; m_rdy = 1;
        if (word[1:0] != 2'b11) begin
          m_insn = {16'h0, word[15:0]}; m_more = 0; m_npc = pc + 2;
        end else begin
          m_insn = word; m_more = 1; m_npc = pc + 4;
        end
      end else begin
        m_addr = pc; m_insn = {16'h0, word[31:16]}; m_more = 1;
        if (word[17:16] != 2'b11) begin
          m_rdy = 1; m_npc = pc + 2;
        end else begin
          m_rdy = 0; m_mid = 1;
        end
      end
    end else if (cons) begin
      m_rdy = 0;
    end
    #(CLK_PERIOD/4);
    chk("R7 model ready", {31'b0, rdy}, {31'b0, m_rdy});
    chk("R2 model insn", insn, m_insn);
    chk("R3 model more", {31'b0, more}, {31'b0, m_more});
    if (m_rdy) begin
      chk("R1 model comp", {31'b0, comp}, {31'b0, m_insn[1:0] != 2'b11});
      chk("R6 model npc", {16'b0, npc}, {16'b0, m_npc});
    end
  end

  task automatic step(input logic v, input logic [31:0] w, input logic [AW-1:0] p,
                      input logic c, input logic f);
    vld = v; word = w; pc = p; cons = c; flush = f;
    @(negedge clk);
    vld = 0; cons = 0; flush = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R8 reset insn", insn, 32'h13);
    chk("R8 reset ready", {31'b0, rdy}, 32'd0);
    chk("R8 reset more", {31'b0, more}, 32'd1);

    step(1, 32'hBEEF_4501, 16'h0100, 0, 0);
    chk("R2 aligned short insn", insn, 32'h0000_4501);
    chk("R2 ready", {31'b0, rdy}, 32'd1);
    chk("R1 comp", {31'b0, comp}, 32'd1);
    chk("R3 more low", {31'b0, more}, 32'd0);
    chk("R6 npc +2", {16'b0, npc}, 32'h0102);

    step(1, 32'h1234_5678, 16'h0200, 0, 0);
    chk("R7 held word ignored", insn, 32'h0000_4501);
    step(1, 32'h00A0_0093, 16'h0200, 1, 0);
    chk("R7 consume+accept", insn, 32'h00A0_0093);
    chk("R1 full comp", {31'b0, comp}, 32'd0);
    chk("R3 full more", {31'b0, more}, 32'd1);
    chk("R6 npc +4", {16'b0, npc}, 32'h0204);

    step(0, 32'h0, 16'h0, 1, 0);
    chk("R7 consume clears", {31'b0, rdy}, 32'd0);

    step(1, 32'h8082_1111, 16'h0302, 0, 0);
    chk("R4 upper short insn", insn, 32'h0000_8082);
    chk("R4 ready", {31'b0, rdy}, 32'd1);
    chk("R3 upper more", {31'b0, more}, 32'd1);
    chk("R6 upper npc", {16'b0, npc}, 32'h0304);

    step(1, 32'h0513_ABCD, 16'h0402, 1, 0);
    chk("R4 pending not ready", {31'b0, rdy}, 32'd0);
    chk("R5 pending low half", insn, 32'h0000_0513);
    step(1, 32'hCAFE_00A5, 16'h0006, 0, 0);
    chk("R5 joined insn", insn, 32'h00A5_0513);
    chk("R5 ready", {31'b0, rdy}, 32'd1);
    chk("R3 joined more", {31'b0, more}, 32'd0);
    chk("R6 span npc", {16'b0, npc}, 32'h0406);

    step(1, 32'h0093_0000, 16'h0502, 1, 0);
    step(1, 32'h0000_0001, 16'h0000, 0, 1);
    chk("R8 flush insn", insn, 32'h13);
    chk("R8 flush ready", {31'b0, rdy}, 32'd0);
    step(1, 32'h0000_0001, 16'h0600, 0, 0);
    chk("R8 pending discarded", insn, 32'h0000_0001);

    step(1, 32'h4501_0000, 16'hFFFE, 1, 0);
    chk("R6 wrap npc", {16'b0, npc}, 32'h0000);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom_range(0, 1) == 1) w[1:0] = 2'b11;
      if ($urandom_range(0, 1) == 1) w[17:16] = 2'b11;
      step($urandom_range(0, 3) != 0, w, AW'({$urandom} & 32'hFFFE),
           $urandom_range(0, 1) == 1, $urandom_range(0, 30) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule